// File: doc/BRIEF.md
# Receive Frame Filter and Descriptor Writer

This block sits on the receive side of an Ethernet controller. It takes an incoming frame one byte at a time and decides whether to keep it. The decision depends on three things: the destination address at the start of the frame, a programmable length ceiling, and two pairs of controls for broadcast and multicast frames. In each pair a "pass" control overrides a "drop" control. When a frame is kept, its bytes are packed into 32-bit words and written into a memory buffer. The buffer is named by a linked chain of three-word descriptors. Once the frame is stored, its descriptor is marked as used.

The first six bytes are held back until the filter has decided, so a rejected frame never touches memory. The length ceiling can only be judged at the end of the frame, so an over-long frame may already have written into its buffer. Such a frame leaves its descriptor untouched and raises no pulse. A frame that finds its descriptor already full is discarded and reported once on an overflow pulse. The engine then switches itself off and stays off until software restarts it.

The memory port uses word addresses. A read returns data on the cycle after the request, and a write completes in the cycle it is issued. The byte input has a ready signal so that the engine can fetch a descriptor before it takes any bytes.

Top module: `rx_frame_keeper`

## Requirements
- R1: After reset the engine is off (`dmaOn`=0), `inReady`, `memReq`, `rxDone` and `rxOverflow` are all 0.
- R2: A frame whose first byte arrives while `cfgRxEnable` or `dmaOn` is 0 is consumed to its last byte. It causes no memory access and no pulse.
- R3: A `dmaStart` pulse sets `dmaOn` and makes the descriptor at word address `ringBase` the current one.
- R4: A descriptor at word address D holds the buffer pointer at D, the size word at D+1 and the next pointer at D+2. It is empty (usable) exactly when bit 31 of the size word is 1.
- R5: Byte i of a kept frame goes to word buffer+i/4, bits 8*(i%4)+7 down to 8*(i%4). Unused upper lanes of the final word are written as 0.
- R6: After a kept frame, the size word is written with the frame length in bits 10:0 and 0 in bits 31:11. `rxDone` pulses for one cycle, and the next pointer becomes the current descriptor.
- R7: A frame longer than `maxFrameLen` is dropped silently. Its size word is not written, there is no pulse, and the same descriptor is used by the next frame. A frame of exactly `maxFrameLen` bytes is kept.
- R8: A destination of six 0xFF bytes is broadcast. It is kept if `bcastPass` is 1; otherwise it is dropped if `bcastDrop` is 1; otherwise it is kept.
- R9: A non-broadcast destination whose first byte has bit 0 set is multicast. It is kept or dropped by the same rule, using `mcastPass` and `mcastDrop`; the broadcast controls have no effect on it.
- R10: Any other destination is kept only if all six bytes equal the station address. Byte 1 of that address is `stationHi`[31:24], bytes 2 to 4 follow down to `stationHi`[7:0], and bytes 5 and 6 are `stationLo`[15:8] and `stationLo`[7:0].
- R11: A frame rejected by the address filter, and a frame shorter than six bytes, cause no memory write and no pulse, and the descriptor is not consumed.
- R12: A frame that passes the filter and length check while the current descriptor is full writes nothing. It gives one `rxOverflow` pulse and clears `dmaOn`. An over-long frame gives no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgRxEnable | input | 1 | MAC receive enable |
| dmaStart | input | 1 | Pulse: switch the engine on and load the descriptor pointer |
| ringBase | input | AW | Word address of the first descriptor |
| dmaOn | output | 1 | Engine enable state |
| maxFrameLen | input | LW | Longest frame kept, in bytes |
| stationHi | input | 32 | Station address bytes 1 to 4, first byte in the top bits |
| stationLo | input | 16 | Station address bytes 5 and 6, byte 5 in the top bits |
| bcastPass | input | 1 | Keep broadcast regardless of bcastDrop |
| bcastDrop | input | 1 | Drop broadcast unless bcastPass |
| mcastPass | input | 1 | Keep multicast regardless of mcastDrop |
| mcastDrop | input | 1 | Drop multicast unless mcastPass |
| inByte | input | 8 | Frame byte |
| inValid | input | 1 | inByte is valid |
| inLast | input | 1 | inByte is the last byte of the frame |
| inReady | output | 1 | Byte accepted at the clock edge when inValid is also 1 |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | AW | Word address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid the cycle after a read request |
| rxDone | output | 1 | One-cycle pulse: frame stored |
| rxOverflow | output | 1 | One-cycle pulse: frame lost to a full descriptor |

## Verification
Some properties are checked by assertions on every cycle. No memory access happens while the engine is off, and a store pulse always coincides with a size-word write that has bit 31 clear. An overflow always leaves the engine off on the next cycle. Done and overflow never pulse together, and the engine never issues a read while it accepts bytes. Other behaviour can only be shown by the bench's scenarios, because it depends on what the frame contains. These are the filter outcomes for each combination of the pass and drop controls, the station-address byte order, the byte lane packing, the length limit at its exact boundary, and whether the descriptor chain advanced or stayed put.

// File: rtl/rxk_pkg.sv
package rxk_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    MEM_IDLE,
    MEM_RD_SIZE,
    MEM_RD_BUF,
    MEM_RD_NEXT,
    MEM_WR_HEAD,
    MEM_WR_TAIL,
    MEM_WR_BYTE,
    MEM_WR_SIZE
  } memOp_e;

  typedef struct packed {
    logic   loadBase;
    logic   capSize;
    logic   capBuf;
    logic   capNext;
    logic   take;
    logic   newFrame;
    logic   advance;
    memOp_e op;
  } rxkStrobe_t;

endpackage

// File: rtl/rxk_datapath.sv
module rxk_datapath
  import rxk_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LW      = 16,
  parameter int SZ_BITS = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxkStrobe_t        sb,
  input  logic [AW-1:0]     ringBase,
  input  logic [7:0]        inByte,
  input  logic              inLast,
  input  logic [LW-1:0]     maxFrameLen,
  input  logic [31:0]       stationHi,
  input  logic [15:0]       stationLo,
  input  logic              bcastPass,
  input  logic              bcastDrop,
  input  logic              mcastPass,
  input  logic              mcastDrop,
  input  logic [WORD_W-1:0] memRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              descEmpty,
  output logic              filterOk,
  output logic              lenOver,
  output logic              atSixth
);

  localparam int DST_BYTES = 6;

  logic [AW-1:0]     descPtr, bufPtr, nextPtr;
  logic [WORD_W-1:0] hdrWord, pack, packNext;
  logic [LW-1:0]     frameLen;
  logic [1:0]        lane;
  logic [7:0]        dst [DST_BYTES];
  logic [7:0]        sta [DST_BYTES];
  logic              isBcast, isMcast, staMatch;

  assign lane = frameLen[1:0];

  always_comb begin
    packNext = (lane == 2'd0) ? '0 : pack;
    for (int k = 0; k < 4; k++)
      if (lane == 2'(k)) packNext[8*k +: 8] = inByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr   <= '0;
      bufPtr    <= '0;
      nextPtr   <= '0;
      descEmpty <= 1'b0;
      hdrWord   <= '0;
      pack      <= '0;
      frameLen  <= '0;
    end else begin
      if (sb.loadBase)     descPtr <= ringBase;
      else if (sb.advance) descPtr <= nextPtr;
      if (sb.capSize) descEmpty <= memRdata[WORD_W-1];
      if (sb.capBuf)  bufPtr    <= memRdata[AW-1:0];
      if (sb.capNext) nextPtr   <= memRdata[AW-1:0];
      if (sb.newFrame) begin
        frameLen <= '0;
        pack     <= '0;
      end else if (sb.take) begin
        pack <= packNext;
        if (frameLen == LW'(3)) hdrWord <= packNext;
        if (frameLen != '1) frameLen <= frameLen + 1'b1;
      end
    end
  end

  // destination bytes as they stand when the sixth one is on the input
  assign dst[0] = hdrWord[7:0];
  assign dst[1] = hdrWord[15:8];
  assign dst[2] = hdrWord[23:16];
  assign dst[3] = hdrWord[31:24];
  assign dst[4] = pack[7:0];
  assign dst[5] = inByte;

  generate
    for (genvar g = 0; g < 4; g++) begin : g_staHi
      assign sta[g] = stationHi[31-8*g -: 8];
    end
    for (genvar g = 0; g < 2; g++) begin : g_staLo
      assign sta[4+g] = stationLo[15-8*g -: 8];
    end
  endgenerate

  always_comb begin
    isBcast  = 1'b1;
    staMatch = 1'b1;
    for (int k = 0; k < DST_BYTES; k++) begin
      if (dst[k] != 8'hFF)  isBcast  = 1'b0;
      if (dst[k] != sta[k]) staMatch = 1'b0;
    end
  end

  assign isMcast  = dst[0][0];
  assign filterOk = isBcast ? (bcastPass || !bcastDrop) :
                    isMcast ? (mcastPass || !mcastDrop) : staMatch;
  assign lenOver  = frameLen > maxFrameLen;
  assign atSixth  = frameLen == LW'(DST_BYTES - 1);

  always_comb begin
    memReq   = 1'b0;
    memWe    = 1'b0;
    memAddr  = '0;
    memWdata = '0;
    unique case (sb.op)
      MEM_RD_SIZE: begin memReq = 1'b1; memAddr = descPtr + AW'(1); end
      MEM_RD_BUF:  begin memReq = 1'b1; memAddr = descPtr; end
      MEM_RD_NEXT: begin memReq = 1'b1; memAddr = descPtr + AW'(2); end
      MEM_WR_HEAD: begin
        memReq = 1'b1; memWe = 1'b1; memAddr = bufPtr; memWdata = hdrWord;
      end
      MEM_WR_TAIL: begin
        memReq = 1'b1; memWe = 1'b1; memAddr = bufPtr + AW'(1); memWdata = pack;
      end
      MEM_WR_BYTE: begin
        memReq   = sb.take && (lane == 2'd3 || inLast);
        memWe    = memReq;
        memAddr  = bufPtr + AW'(frameLen >> 2);
        memWdata = packNext;
      end
      MEM_WR_SIZE: begin
        memReq   = 1'b1;
        memWe    = 1'b1;
        memAddr  = descPtr + AW'(1);
        memWdata = {{(WORD_W-SZ_BITS){1'b0}}, frameLen[SZ_BITS-1:0]};
      end
      default: ;
    endcase
  end

  // R7: the byte count saturates instead of wrapping to a small length
  p_len_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    sb.take && !sb.newFrame && frameLen == '1 |=> frameLen == '1);

endmodule

// File: rtl/rxk_control.sv
module rxk_control
  import rxk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgRxEnable,
  input  logic       dmaStart,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       descEmpty,
  input  logic       filterOk,
  input  logic       lenOver,
  input  logic       atSixth,
  output rxkStrobe_t sb,
  output logic       inReady,
  output logic       dmaOn,
  output logic       rxDone,
  output logic       rxOverflow
);

  typedef enum logic [3:0] {
    S_IDLE, S_SKIP, S_RDSIZE, S_RDBUF, S_RDNEXT, S_GETNEXT,
    S_HDR, S_FLUSH, S_TAIL, S_BODY, S_DRAIN, S_CLOSE, S_OVCHK
  } state_e;

  state_e state, nxt;
  logic   endSeen, endNext;

  always_comb begin
    sb          = '0;
    sb.loadBase = dmaStart;
    nxt         = state;
    endNext     = endSeen;
    inReady     = 1'b0;
    rxDone      = 1'b0;
    rxOverflow  = 1'b0;
    unique case (state)
      S_IDLE: if (inValid) begin
        sb.newFrame = 1'b1;
        nxt = (cfgRxEnable && dmaOn) ? S_RDSIZE : S_SKIP;
      end
      S_SKIP: begin
        inReady = 1'b1;
        if (inValid && inLast) nxt = S_IDLE;
      end
      S_RDSIZE:  begin sb.op = MEM_RD_SIZE; nxt = S_RDBUF; end
      S_RDBUF:   begin sb.op = MEM_RD_BUF;  sb.capSize = 1'b1; nxt = S_RDNEXT; end
      S_RDNEXT:  begin sb.op = MEM_RD_NEXT; sb.capBuf  = 1'b1; nxt = S_GETNEXT; end
      S_GETNEXT: begin sb.capNext = 1'b1; nxt = S_HDR; end
      S_HDR: begin
        inReady = 1'b1;
        if (inValid) begin
          sb.take = 1'b1;
          if (atSixth) begin
            if (!filterOk)       nxt = inLast ? S_IDLE  : S_SKIP;
            else if (!descEmpty) nxt = inLast ? S_OVCHK : S_DRAIN;
            else begin
              endNext = inLast;
              nxt     = S_FLUSH;
            end
          end else if (inLast) nxt = S_IDLE;
        end
      end
      S_FLUSH: begin sb.op = MEM_WR_HEAD; nxt = endSeen ? S_TAIL : S_BODY; end
      S_TAIL:  begin sb.op = MEM_WR_TAIL; nxt = S_CLOSE; end
      S_BODY: begin
        inReady = 1'b1;
        sb.op   = MEM_WR_BYTE;
        if (inValid) begin
          sb.take = 1'b1;
          if (inLast) nxt = S_CLOSE;
        end
      end
      S_DRAIN: begin
        inReady = 1'b1;
        if (inValid) begin
          sb.take = 1'b1;
          if (inLast) nxt = S_OVCHK;
        end
      end
      S_CLOSE: begin
        if (!lenOver) begin
          sb.op      = MEM_WR_SIZE;
          sb.advance = 1'b1;
          rxDone     = 1'b1;
        end
        nxt = S_IDLE;
      end
      S_OVCHK: begin
        rxOverflow = !lenOver;
        nxt        = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      endSeen <= 1'b0;
      dmaOn   <= 1'b0;
    end else begin
      state   <= nxt;
      endSeen <= endNext;
      if (dmaStart)        dmaOn <= 1'b1;
      else if (rxOverflow) dmaOn <= 1'b0;
    end
  end

  // R12: an overflow leaves the engine off unless restarted in that cycle
  p_ovf_off_r12: assert property (@(posedge clk) disable iff (!rstN)
    rxOverflow && !dmaStart |=> !dmaOn);

  // R4: no descriptor read is issued while bytes are being accepted
  p_ready_no_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !(sb.op inside {MEM_RD_SIZE, MEM_RD_BUF, MEM_RD_NEXT}));

endmodule

// File: rtl/rx_frame_keeper.sv
module rx_frame_keeper
  import rxk_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LW      = 16,
  parameter int SZ_BITS = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgRxEnable,
  input  logic              dmaStart,
  input  logic [AW-1:0]     ringBase,
  output logic              dmaOn,
  input  logic [LW-1:0]     maxFrameLen,
  input  logic [31:0]       stationHi,
  input  logic [15:0]       stationLo,
  input  logic              bcastPass,
  input  logic              bcastDrop,
  input  logic              mcastPass,
  input  logic              mcastDrop,
  input  logic [7:0]        inByte,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic              memReq,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic              rxDone,
  output logic              rxOverflow
);

  rxkStrobe_t sb;
  logic descEmpty, filterOk, lenOver, atSixth;

  rxk_control i_ctl (
    .clk(clk), .rstN(rstN), .cfgRxEnable(cfgRxEnable), .dmaStart(dmaStart),
    .inValid(inValid), .inLast(inLast), .descEmpty(descEmpty),
    .filterOk(filterOk), .lenOver(lenOver), .atSixth(atSixth), .sb(sb),
    .inReady(inReady), .dmaOn(dmaOn), .rxDone(rxDone), .rxOverflow(rxOverflow)
  );

  rxk_datapath #(.AW(AW), .LW(LW), .SZ_BITS(SZ_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .sb(sb), .ringBase(ringBase), .inByte(inByte),
    .inLast(inLast), .maxFrameLen(maxFrameLen), .stationHi(stationHi),
    .stationLo(stationLo), .bcastPass(bcastPass), .bcastDrop(bcastDrop),
    .mcastPass(mcastPass), .mcastDrop(mcastDrop), .memRdata(memRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .descEmpty(descEmpty), .filterOk(filterOk), .lenOver(lenOver),
    .atSixth(atSixth)
  );

  // R2: memory is touched only while the engine is on
  p_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> dmaOn);

  // R6: a store pulse coincides with a size write marking the slot used
  p_done_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> memWe && !memWdata[WORD_W-1]);

  // R12: a frame is either stored or lost, never both
  p_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(rxDone && rxOverflow));

endmodule

// File: tb/test_rx_frame_keeper.sv
`timescale 1ns/1ps
module test_rx_frame_keeper;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgRxEnable = 1'b0, dmaStart = 1'b0;
  logic [31:0] ringBase = '0;
  logic        dmaOn;
  logic [15:0] maxFrameLen = 16'h0600;
  logic [31:0] stationHi = 32'h0211_2233;
  logic [15:0] stationLo = 16'h4455;
  logic        bcastPass = 1'b0, bcastDrop = 1'b0, mcastPass = 1'b0, mcastDrop = 1'b0;
  logic [7:0]  inByte = '0;
  logic        inValid = 1'b0, inLast = 1'b0, inReady;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        rxDone, rxOverflow;

  always #4 clk = ~clk;

  rx_frame_keeper i_rx_frame_keeper (.*);

  // memory model: read data one cycle after request
  logic [31:0] mem [0:1023];
  logic [31:0] rdq = '0;
  logic        tbWe = 1'b0;
  logic [9:0]  tbAddr = '0;
  logic [31:0] tbData = '0;
  int doneCnt = 0, ovfCnt = 0, wrCnt = 0;
  assign memRdata = rdq;

  always @(posedge clk) begin
    if (tbWe) mem[tbAddr] <= tbData;
    else if (memReq && memWe) mem[memAddr[9:0]] <= memWdata;
    rdq <= mem[memAddr[9:0]];
    if (rstN) begin
      if (rxDone) doneCnt <= doneCnt + 1;
      if (rxOverflow) ovfCnt <= ovfCnt + 1;
      if (memReq && memWe) wrCnt <= wrCnt + 1;
    end
  end

  int total = 0, fails = 0;
  logic [7:0] fb [0:63];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setMem(input int a, input logic [31:0] d);
    @(negedge clk); tbWe = 1'b1; tbAddr = 10'(a); tbData = d;
    @(negedge clk); tbWe = 1'b0;
  endtask

  // descriptor pair at 16*k, buffers at 512+32*k and +16; optional full size word
  task automatic prep(input int k, input logic [31:0] size0);
    setMem(16*k,     32'(512 + 32*k));
    setMem(16*k + 1, size0);
    setMem(16*k + 2, 32'(16*k + 8));
    setMem(16*k + 8, 32'(512 + 32*k + 16));
    setMem(16*k + 9, 32'h8000_0000);
    setMem(16*k + 10, 32'(16*k + 16));
    @(negedge clk); ringBase = 32'(16*k); dmaStart = 1'b1;
    @(negedge clk); dmaStart = 1'b0;
  endtask

  task automatic setDst(input logic [47:0] d);
    for (int i = 0; i < 6; i++) fb[i] = d[47-8*i -: 8];
    for (int i = 6; i < 64; i++) fb[i] = 8'(i * 7 + 3);
  endtask

  task automatic sendFrame(input int len);
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1; inByte = fb[i]; inLast = (i == len - 1);
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0; inLast = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [31:0] expWord(input int len, input int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (4*w + k < len) r[8*k +: 8] = fb[4*w + k];
    return r;
  endfunction

  task automatic expectKept(input string tag, input int desc, input int buf0, input int len, input int d0);
    chk({tag, " done pulse"}, 32'(doneCnt - d0), 32'd1);
    chk({tag, " size word"}, mem[desc + 1], 32'(len));
    for (int w = 0; w < (len + 3) / 4; w++)
      chk({tag, " buffer word"}, mem[buf0 + w], expWord(len, w));
  endtask

  task automatic expectDropped(input string tag, input int desc, input int d0, input int w0);
    chk({tag, " no done"}, 32'(doneCnt - d0), 32'd0);
    chk({tag, " no write"}, 32'(wrCnt - w0), 32'd0);
    chk({tag, " slot still empty"}, mem[desc + 1], 32'h8000_0000);
  endtask

  localparam logic [47:0] STA = 48'h0211_2233_4455;

  task automatic t_reset;
    chk("R1 dmaOn", 32'(dmaOn), 0);
    chk("R1 inReady", 32'(inReady), 0);
    chk("R1 memReq", 32'(memReq), 0);
    chk("R1 pulses", 32'({rxDone, rxOverflow}), 0);
  endtask

  task automatic t_disabled;
    int d0, w0;
    cfgRxEnable = 1'b1; setDst(STA);
    d0 = doneCnt; w0 = wrCnt; sendFrame(8);
    chk("R2 engine off no write", 32'(wrCnt - w0), 0);
    chk("R2 engine off no done", 32'(doneCnt - d0), 0);
    prep(11, 32'h8000_0000); cfgRxEnable = 1'b0;
    d0 = doneCnt; w0 = wrCnt; sendFrame(8);
    expectDropped("R2 mac off", 176, d0, w0);
    cfgRxEnable = 1'b1;
  endtask

  task automatic t_unicast;
    int d0;
    prep(1, 32'h8000_0000);
    chk("R3 dmaOn set", 32'(dmaOn), 1);
    setDst(STA); d0 = doneCnt; sendFrame(11);
    expectKept("R3 R4 R5 R10 unicast", 16, 544, 11, d0);
    fb[6] = 8'hA5; d0 = doneCnt; sendFrame(6);
    expectKept("R6 advanced six-byte", 24, 560, 6, d0);
  endtask

  task automatic t_mismatch;
    int d0, w0;
    prep(2, 32'h8000_0000);
    setDst(48'h0211_2233_4456); d0 = doneCnt; w0 = wrCnt; sendFrame(10);
    expectDropped("R10 last byte differs", 32, d0, w0);
    setDst(48'h0011_2233_4455); sendFrame(10);
    expectDropped("R10 first byte differs", 32, d0, w0);
    setDst(STA); sendFrame(4);
    expectDropped("R11 short frame", 32, d0, w0);
    sendFrame(9);
    expectKept("R11 slot kept for next", 32, 576, 9, d0);
  endtask

  task automatic filtCase(input string tag, input int k, input logic [47:0] d, input bit keep);
    int d0, w0;
    prep(k, 32'h8000_0000);
    setDst(d); d0 = doneCnt; w0 = wrCnt; sendFrame(12);
    if (keep) expectKept(tag, 16*k, 512 + 32*k, 12, d0);
    else      expectDropped(tag, 16*k, d0, w0);
  endtask

  task automatic t_bcast;
    bcastPass = 0; bcastDrop = 0; filtCase("R8 bcast default keep", 3, 48'hFFFF_FFFF_FFFF, 1);
    bcastPass = 0; bcastDrop = 1; filtCase("R8 bcast drop", 4, 48'hFFFF_FFFF_FFFF, 0);
    bcastPass = 1; bcastDrop = 1; filtCase("R8 bcast pass overrides", 5, 48'hFFFF_FFFF_FFFF, 1);
    bcastPass = 0; bcastDrop = 0;
  endtask

  task automatic t_mcast;
    mcastPass = 0; mcastDrop = 1; filtCase("R9 mcast drop", 6, 48'h0100_5E00_0001, 0);
    mcastPass = 1; mcastDrop = 1; filtCase("R9 mcast pass overrides", 7, 48'h0100_5E00_0001, 1);
    mcastPass = 0; mcastDrop = 0; bcastDrop = 1;
    filtCase("R9 bcast ctl no effect", 8, 48'h0100_5E00_0001, 1);
    bcastDrop = 0;
  endtask

  task automatic t_length;
    int d0;
    prep(9, 32'h8000_0000); maxFrameLen = 16'd8; setDst(STA);
    d0 = doneCnt; sendFrame(9);
    chk("R7 over-long no done", 32'(doneCnt - d0), 0);
    chk("R7 over-long slot empty", mem[145], 32'h8000_0000);
    d0 = doneCnt; sendFrame(8);
    expectKept("R7 exact limit same slot", 144, 800, 8, d0);
    maxFrameLen = 16'h0600;
  endtask

  task automatic t_overflow;
    int d0, w0, o0;
    prep(10, 32'h0000_0005); setDst(STA);
    d0 = doneCnt; w0 = wrCnt; o0 = ovfCnt; sendFrame(10);
    chk("R12 overflow pulse", 32'(ovfCnt - o0), 1);
    chk("R12 no write", 32'(wrCnt - w0), 0);
    chk("R12 no done", 32'(doneCnt - d0), 0);
    chk("R12 engine off", 32'(dmaOn), 0);
    chk("R12 size untouched", mem[161], 32'h0000_0005);
    sendFrame(10);
    chk("R12 later frame ignored", 32'(ovfCnt - o0), 1);
    chk("R12 later frame no write", 32'(wrCnt - w0), 0);
    @(negedge clk); ringBase = 32'd160; dmaStart = 1'b1;
    @(negedge clk); dmaStart = 1'b0; maxFrameLen = 16'd8;
    sendFrame(10);
    chk("R12 over-long gives no overflow", 32'(ovfCnt - o0), 1);
    chk("R12 engine stays on", 32'(dmaOn), 1);
    maxFrameLen = 16'h0600;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_unicast();
    t_mismatch();
    t_bcast();
    t_mcast();
    t_length();
    t_overflow();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule